// File: doc/BRIEF.md
# Potts Annealing Feedback Update Unit

This block computes the per-iteration feedback for a small Potts-model max-K-cut solver in which every node holds one of four colors. When an iteration is launched, the block takes a snapshot of the one-hot colors of all nodes. It then visits the nodes one at a time. For each node it reads that node's row of a stored adjacency matrix and counts how many neighbours currently hold each color. That count is the energy gradient for the color, because a neighbour of the same color adds to the cut energy and there is no bias term.

The probability update is the negative gradient, scaled by an annealing coefficient `b` held as an unsigned fixed-point number with two fraction bits. The block subtracts the scaled update from a base level and saturates the result to the ten quantization levels 0..9. It then maps the result through a calibration table to a drive code. The four codes of a node always come out together, so all of them follow from the same neighbour feedback. Each node's result leaves on a valid/ready stream: a beat is offered and held unchanged until it is accepted, and the block does not move to the next node while the consumer stalls.

After the last node is accepted, the block pulses a completion flag and raises `b` by a fixed step, saturating at a ceiling. A larger `b` pushes the targets of conflicting colors down harder, which lowers the effective temperature. A restart input returns `b` to its starting value.

Top module: `potts_fb_unit`

## Requirements
- R1: For node i and color k, the gradient g is the number of nodes j with j != i, bit j of adjacency row i set, and bit k of node j's one-hot state set. Node j's state occupies `node_state[j*4 +: 4]`, and bit k set means color k.
- R2: The level for color k is max(0, 8 - floor(b*g/4)) capped at 9. The output is the code table entry for that level, and the default table for levels 0..9 is 10, 20, 36, 55, 78, 104, 131, 160, 190, 222. Color k's code sits in `out_codes[k*8 +: 8]`.
- R3: The diagonal bit of an adjacency row (a node's own bit) does not contribute to any gradient.
- R4: A gradient large enough to drive the level below zero saturates at level 0 (code 10). No code outside the table is produced.
- R5: Each iteration emits exactly one beat per node, in node order 0..7, with the node index on `out_node`.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_node` and `out_codes` hold their values on the next cycle.
- R7: `iter_done` is a one-cycle pulse in the cycle after the handshake of node 7's beat, and it is never high at any other time.
- R8: A high `anneal_start` sets `anneal_b` to its initial value 4 (1.0) on the next cycle. When a completion happens in the same cycle, the restart takes precedence.
- R9: Each completed iteration raises `anneal_b` by 2 (0.5), saturating at 16 (4.0). The new value is visible in the same cycle as `iter_done`.
- R10: Node states are captured when `iter_go` is accepted. Changes to `node_state` during an iteration do not affect that iteration's codes.
- R11: While an iteration is in progress, adjacency writes and `iter_go` are ignored.
- R12: After reset, `out_valid` and `iter_done` are low, `anneal_b` is 4, and every adjacency bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| anneal_start | input | 1 | Return the annealing coefficient to its initial value |
| iter_go | input | 1 | Launch one feedback iteration (accepted when idle) |
| adj_we | input | 1 | Adjacency row write strobe (accepted when idle) |
| adj_row_sel | input | 3 | Row index for the adjacency write |
| adj_row_data | input | 8 | Row contents; bit j marks node j as a neighbour |
| node_state | input | 32 | One-hot colors of all nodes, 4 bits per node |
| out_valid | output | 1 | A node's code beat is offered |
| out_ready | input | 1 | Consumer accepts the beat |
| out_node | output | 3 | Node index of the offered beat |
| out_codes | output | 32 | Four 8-bit drive codes, color k at bits k*8 |
| iter_done | output | 1 | One-cycle pulse when all nodes of an iteration are accepted |
| anneal_b | output | 8 | Current annealing coefficient, two fraction bits |

## Verification
The bench targets gradient corner cases. A set diagonal bit must not add to the node's own count; if it did, that node's codes would drop by one or more levels. A hub node whose neighbours all share one color must saturate at code 10 once `b` is large; a design without the floor would wrap around to a high code. The bench also ramps `b` through eight iterations so that it stays pinned at 16, and a missing ceiling would keep lowering the mid-level codes. During an iteration the bench changes `node_state`, writes an adjacency row and repeats `iter_go`. A design that reads live inputs or accepts these during the iteration would emit wrong codes for that iteration or the following one, or extra beats. Random stalls on `out_ready` expose a beat that changes or is skipped while it waits.

// File: rtl/potts_fb_pkg.sv
package potts_fb_pkg;

  typedef enum logic [1:0] {
    FB_IDLE = 2'd0,
    FB_CALC = 2'd1,
    FB_EMIT = 2'd2
  } fb_state_e;

endpackage

// File: rtl/potts_grad.sv
module potts_grad #(
  parameter int N     = 8,
  parameter int K     = 4,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [N-1:0]       row_i,
  input  logic [N*K-1:0]     states_i,
  input  logic [IDX_W-1:0]   self_i,
  output logic [K*CNT_W-1:0] counts_o
);

  for (genvar k = 0; k < K; k++) begin : g_color
    logic [CNT_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < N; j++) begin
        if (row_i[j] && (IDX_W'(j) != self_i) && states_i[j*K+k])
          acc = acc + CNT_W'(1);
      end
    end
    assign counts_o[k*CNT_W +: CNT_W] = acc;
  end

endmodule

// File: rtl/potts_target_map.sv
module potts_target_map #(
  parameter int K        = 4,
  parameter int CNT_W    = 4,
  parameter int B_W      = 8,
  parameter int B_FRAC   = 2,
  parameter int LEVELS   = 10,
  parameter int BASE_LVL = 8,
  parameter int CODE_W   = 8,
  parameter logic [CODE_W-1:0] LUT [LEVELS] = '{default: '0}
) (
  input  logic [B_W-1:0]      b_i,
  input  logic [K*CNT_W-1:0]  counts_i,
  output logic [K*CODE_W-1:0] codes_o
);

  localparam int PROD_W = B_W + CNT_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [PROD_W-1:0] BASE_V = PROD_W'(BASE_LVL);
  localparam logic [PROD_W-1:0] TOP_V  = PROD_W'(LEVELS - 1);

  for (genvar k = 0; k < K; k++) begin : g_color
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] delta;
    logic [PROD_W-1:0] lvl_raw;
    logic [PROD_W-1:0] lvl_sat;
    logic [LVL_W-1:0]  lvl;

    always_comb begin
      prod    = PROD_W'(b_i) * PROD_W'(counts_i[k*CNT_W +: CNT_W]);
      delta   = prod >> B_FRAC;
      lvl_raw = (delta >= BASE_V) ? '0 : (BASE_V - delta);
      lvl_sat = (lvl_raw > TOP_V) ? TOP_V : lvl_raw;
      lvl     = LVL_W'(lvl_sat);
    end

    assign codes_o[k*CODE_W +: CODE_W] = LUT[lvl];
  end

endmodule

// File: rtl/potts_b_ramp.sv
module potts_b_ramp #(
  parameter int B_W    = 8,
  parameter int B_INIT = 4,
  parameter int B_STEP = 2,
  parameter int B_MAX  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart_i,
  input  logic           advance_i,
  output logic [B_W-1:0] b_o
);

  logic [B_W:0] sum;
  assign sum = {1'b0, b_o} + (B_W+1)'(B_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_o <= B_W'(B_INIT);
    end else if (restart_i) begin
      b_o <= B_W'(B_INIT);
    end else if (advance_i) begin
      b_o <= (sum > (B_W+1)'(B_MAX)) ? B_W'(B_MAX) : sum[B_W-1:0];
    end
  end

endmodule

// File: rtl/potts_fb_unit.sv
module potts_fb_unit #(
  parameter int N_NODES  = 8,
  parameter int N_COLORS = 4,
  parameter int LEVELS   = 10,
  parameter int CODE_W   = 8,
  parameter int B_W      = 8,
  parameter int B_FRAC   = 2,
  parameter int BASE_LVL = 8,
  parameter int B_INIT   = 4,
  parameter int B_STEP   = 2,
  parameter int B_MAX    = 16,
  parameter logic [CODE_W-1:0] LUT [LEVELS] =
    '{8'd10, 8'd20, 8'd36, 8'd55, 8'd78, 8'd104, 8'd131, 8'd160, 8'd190, 8'd222},
  localparam int IDX_W = $clog2(N_NODES),
  localparam int CNT_W = $clog2(N_NODES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         anneal_start,
  input  logic                         iter_go,
  input  logic                         adj_we,
  input  logic [IDX_W-1:0]             adj_row_sel,
  input  logic [N_NODES-1:0]           adj_row_data,
  input  logic [N_NODES*N_COLORS-1:0]  node_state,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [IDX_W-1:0]             out_node,
  output logic [N_COLORS*CODE_W-1:0]   out_codes,
  output logic                         iter_done,
  output logic [B_W-1:0]               anneal_b
);

  import potts_fb_pkg::*;

  fb_state_e                        st;
  logic [N_NODES-1:0]               adj_mem [N_NODES];
  logic [N_NODES*N_COLORS-1:0]      snap;
  logic [IDX_W-1:0]                 node;
  logic [N_COLORS*CNT_W-1:0]        counts;
  logic [N_COLORS*CODE_W-1:0]       codes_c;
  logic                             last_hs;

  assign last_hs  = (st == FB_EMIT) && out_ready && (node == IDX_W'(N_NODES - 1));
  assign out_node = node;

  // adjacency storage, writable only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_NODES; r++) adj_mem[r] <= '0;
    end else if (adj_we && (st == FB_IDLE)) begin
      adj_mem[adj_row_sel] <= adj_row_data;
    end
  end

  potts_grad #(
    .N(N_NODES), .K(N_COLORS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_grad (
    .row_i    (adj_mem[node]),
    .states_i (snap),
    .self_i   (node),
    .counts_o (counts)
  );

  potts_target_map #(
    .K(N_COLORS), .CNT_W(CNT_W), .B_W(B_W), .B_FRAC(B_FRAC),
    .LEVELS(LEVELS), .BASE_LVL(BASE_LVL), .CODE_W(CODE_W), .LUT(LUT)
  ) u_map (
    .b_i      (anneal_b),
    .counts_i (counts),
    .codes_o  (codes_c)
  );

  potts_b_ramp #(
    .B_W(B_W), .B_INIT(B_INIT), .B_STEP(B_STEP), .B_MAX(B_MAX)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (anneal_start),
    .advance_i (last_hs),
    .b_o       (anneal_b)
  );

  // node sequencer and output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FB_IDLE;
      snap      <= '0;
      node      <= '0;
      out_valid <= 1'b0;
      out_codes <= '0;
      iter_done <= 1'b0;
    end else begin
      iter_done <= 1'b0;
      unique case (st)
        FB_IDLE: begin
          if (iter_go) begin
            snap <= node_state;
            node <= '0;
            st   <= FB_CALC;
          end
        end
        FB_CALC: begin
          out_codes <= codes_c;
          out_valid <= 1'b1;
          st        <= FB_EMIT;
        end
        FB_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            if (last_hs) begin
              iter_done <= 1'b1;
              st        <= FB_IDLE;
            end else begin
              node <= node + IDX_W'(1);
              st   <= FB_CALC;
            end
          end
        end
        default: st <= FB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/potts_fb_chk.sv
module potts_fb_chk #(
  parameter int N_NODES = 8,
  parameter int N_COLORS = 4,
  parameter int CODE_W = 8,
  parameter int B_W = 8,
  parameter int B_INIT = 4,
  parameter int B_MAX = 16,
  parameter int IDX_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       anneal_start,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [IDX_W-1:0]           out_node,
  input logic [N_COLORS*CODE_W-1:0] out_codes,
  input logic                       iter_done,
  input logic [B_W-1:0]             anneal_b
);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_node) && $stable(out_codes)));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |-> $past(out_valid && out_ready && (out_node == IDX_W'(N_NODES - 1))));

  // R8
  start_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anneal_start |=> (anneal_b == B_W'(B_INIT)));

  // R9
  b_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && !$past(anneal_start)) |-> ((anneal_b > $past(anneal_b)) || (anneal_b == B_W'(B_MAX))));

  // R9
  b_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (anneal_b <= B_W'(B_MAX)) && (anneal_b >= B_W'(B_INIT)));

endmodule

bind potts_fb_unit potts_fb_chk #(
  .N_NODES(N_NODES), .N_COLORS(N_COLORS), .CODE_W(CODE_W), .B_W(B_W),
  .B_INIT(B_INIT), .B_MAX(B_MAX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .anneal_start(anneal_start),
  .out_valid(out_valid), .out_ready(out_ready), .out_node(out_node),
  .out_codes(out_codes), .iter_done(iter_done), .anneal_b(anneal_b)
);

// File: tb/tb_potts_fb_unit.sv
`timescale 1ns/1ps
module tb_potts_fb_unit;

  localparam int N = 8;
  localparam int K = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic anneal_start = 1'b0;
  logic iter_go = 1'b0;
  logic adj_we = 1'b0;
  logic [2:0] adj_row_sel = '0;
  logic [N-1:0] adj_row_data = '0;
  logic [N*K-1:0] node_state = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2:0] out_node;
  logic [K*CW-1:0] out_codes;
  logic iter_done;
  logic [7:0] anneal_b;

  always #2.5 clk = ~clk;

  potts_fb_unit dut (
    .clk(clk), .rst_n(rst_n), .anneal_start(anneal_start), .iter_go(iter_go),
    .adj_we(adj_we), .adj_row_sel(adj_row_sel), .adj_row_data(adj_row_data),
    .node_state(node_state), .out_valid(out_valid), .out_ready(out_ready),
    .out_node(out_node), .out_codes(out_codes), .iter_done(iter_done),
    .anneal_b(anneal_b)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int lut_m [10] = '{10, 20, 36, 55, 78, 104, 131, 160, 190, 222};
  bit adj_m [N][N];
  int color_m [N];
  int b_m = 4;

  int exp_node_q [$];
  logic [K*CW-1:0] exp_code_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [N*K-1:0] pack_state();
    logic [N*K-1:0] v = '0;
    for (int j = 0; j < N; j++) v[j*K + color_m[j]] = 1'b1;
    return v;
  endfunction

  // R1 R2 R3 R4: expected code from the bench's own model
  function automatic logic [K*CW-1:0] exp_codes(input int i, input int b);
    logic [K*CW-1:0] v = '0;
    for (int k = 0; k < K; k++) begin
      int g = 0;
      int lvl;
      for (int j = 0; j < N; j++)
        if (j != i && adj_m[i][j] && color_m[j] == k) g++;
      lvl = 8 - (b * g) / 4;
      if (lvl < 0) lvl = 0;
      if (lvl > 9) lvl = 9;
      v[k*CW +: CW] = CW'(lut_m[lvl]);
    end
    return v;
  endfunction

  task automatic write_row(input int r, input logic [N-1:0] d, input bit update_model);
    @(negedge clk);
    adj_we = 1'b1; adj_row_sel = 3'(r); adj_row_data = d;
    @(negedge clk);
    adj_we = 1'b0;
    if (update_model) for (int j = 0; j < N; j++) adj_m[r][j] = d[j];
  endtask

  // driver: pushes expected beats, launches, optionally disturbs (R10 R11)
  task automatic run_iter(input bit disturb);
    int nb;
    for (int i = 0; i < N; i++) begin
      exp_node_q.push_back(i);
      exp_code_q.push_back(exp_codes(i, b_m));
    end
    @(negedge clk);
    node_state = pack_state();
    iter_go = 1'b1;
    @(negedge clk);
    iter_go = 1'b0;
    if (disturb) begin
      node_state = ~pack_state();
      adj_we = 1'b1; adj_row_sel = 3'd7; adj_row_data = 8'h00;
      iter_go = 1'b1;
      @(negedge clk);
      adj_we = 1'b0; iter_go = 1'b0;
    end
    while (!iter_done) @(negedge clk);
    nb = b_m + 2;
    if (nb > 16) nb = 16;
    b_m = nb;
    // R9
    check(anneal_b == 8'(b_m), "R9 b after iteration", anneal_b, b_m);
    // R5
    check(exp_node_q.size() == 0, "R5 beats left", exp_node_q.size(), 0);
    node_state = pack_state();
  endtask

  // monitor: ready pattern, scoreboard pop, stall and done tracking
  logic [7:0] lf = 8'hA5;
  bit stall_prev = 1'b0;
  logic [K*CW-1:0] stall_codes;
  logic [2:0] stall_node;
  bit pend_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (stall_prev) begin
        // R6
        check(out_valid && out_codes == stall_codes && out_node == stall_node,
              "R6 held beat", int'(out_codes), int'(stall_codes));
      end
      if (pend_done) begin
        // R7
        check(iter_done == 1'b1, "R7 done pulse", iter_done, 1);
        pend_done = 1'b0;
      end else if (iter_done) begin
        check(1'b0, "R7 stray done", 1, 0);
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[2];
      stall_prev = out_valid && !out_ready;
      stall_codes = out_codes;
      stall_node = out_node;
      if (out_valid && out_ready) begin
        if (exp_node_q.size() == 0) begin
          check(1'b0, "R11 unexpected beat", int'(out_node), -1);
        end else begin
          int en;
          logic [K*CW-1:0] ec;
          en = exp_node_q.pop_front();
          ec = exp_code_q.pop_front();
          // R5
          check(int'(out_node) == en, "R5 node order", out_node, en);
          // R2
          check(out_codes == ec, "R2 codes", int'(out_codes), int'(ec));
          if (en == N - 1) pend_done = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      color_m[i] = 0;
      for (int j = 0; j < N; j++) adj_m[i][j] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(out_valid == 1'b0, "R12 valid low", out_valid, 0);
    check(iter_done == 1'b0, "R12 done low", iter_done, 0);
    check(anneal_b == 8'd4, "R12 b init", anneal_b, 4);

    // R12: empty adjacency gives the base level everywhere
    color_m = '{0, 1, 2, 3, 0, 1, 2, 3};
    run_iter(1'b0);

    // graph: ring, hub node 7 linked to all, diagonal bit on row 0 (R3)
    color_m = '{0, 0, 1, 2, 0, 3, 0, 1};
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] row = '0;
      row[(i + 1) % N] = 1'b1;
      row[(i + N - 1) % N] = 1'b1;
      row[7] = (i != 7);
      if (i == 7) row = 8'h7F;
      if (i == 0) row[0] = 1'b1;
      write_row(i, row, 1'b1);
    end
    adj_m[0][0] = 1'b1;

    // R9 ramp to the ceiling; R4 hub saturates at level 0
    run_iter(1'b0);
    run_iter(1'b1);  // R10 R11 disturbance mid-iteration
    for (int it = 0; it < 6; it++) run_iter(1'b0);
    check(anneal_b == 8'd16, "R9 ceiling", anneal_b, 16);
    // R4: hub node 7 has four color-0 neighbours; b=16 gives level 0
    check(exp_codes(7, 16)[7:0] == 8'd10, "R4 model floor", exp_codes(7, 16)[7:0], 10);

    // R8 restart
    @(negedge clk);
    anneal_start = 1'b1;
    @(negedge clk);
    anneal_start = 1'b0;
    b_m = 4;
    check(anneal_b == 8'd4, "R8 restart", anneal_b, 4);
    // R11: row 7 write during busy must not have landed
    run_iter(1'b0);

    repeat (4) @(negedge clk);
    check(exp_node_q.size() == 0, "R5 queue drained", exp_node_q.size(), 0);
    summary();
  end

endmodule